// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes. Each single-cycle 1 Hz enable advances seconds, and carries ripple into minutes, hours, day of week, day of month, month and year within that same clock cycle. The number of days in the current month, including February in leap years, is derived from the month and year fields. A century flag inverts at the 99-to-00 year rollover, but only while its enable bit is set.

A host sets any field through a byte-wide write port that selects one register by address. The outputs form a flat bus of seven bytes that matches the register map. Either a stop bit held in the seconds byte or a separate stop request pin freezes all counting. Writing the seconds byte also sends a one-cycle pulse to clear an external sub-second prescaler, so the next second starts from a clean boundary. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, bytes 0 to 6 of `cal_bytes` read 00, 00, 00, 01, 01, 01, 00, and `subsec_clr` is 0.
- R2: One tick raises seconds by one in BCD, so 09 becomes 10. Seconds wrap 59 to 00 and minutes wrap 59 to 00, each carrying into the next field. Hours wrap 23 to 00 and carry into the day fields.
- R3: No field advances on a tick while the stop bit (byte 0 bit 7) is 1 or while `stop_req` is 1. Counting resumes on the first tick after both are 0.
- R4: The day of week sits in byte 3 bits 2:0. It counts 1 to 7 and wraps from 7 to 1 at midnight, whatever the date is.
- R5: The date (byte 4) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. It wraps after 28 in February of a common year. Each date wrap advances the month.
- R6: A BCD year that is a multiple of four, 00 included, is a leap year, and its February has 29 days.
- R7: The month (byte 5) wraps from 12 to 01 and advances the year (byte 6). The year wraps from 99 to 00.
- R8: Byte 2 holds hours in bits 5:0, the century bit in bit 6 and the century enable in bit 7. The century bit inverts when the year wraps from 99 to 00 with the enable at 1. It holds when the enable is 0.
- R9: When `wr_en` is high, `wr_data` is loaded into the byte at `wr_addr`, which runs from 0 to 6. Bits outside each field read as zero: bit 7 of byte 1, bits 7:3 of byte 3, bits 7:6 of byte 4 and bits 7:5 of byte 5. A write to address 7 changes nothing.
- R10: A write takes priority over a tick in the same cycle for the field it addresses. The written field produces no carry in that cycle, while the fields below it still advance.
- R11: `subsec_clr` is 1 for exactly the one cycle after a write to address 0, and is 0 after writes to any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| stop_req | input | 1 | Freezes counting while high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Byte address of the write |
| wr_data | input | 8 | Byte to be written |
| cal_bytes | output | 56 | Register bytes; byte k at bits 8k+7:8k |
| subsec_clr | output | 1 | One-cycle prescaler clear after a seconds write |

## Verification
The assertions assume that `tick_1hz` is a single-cycle pulse and that every value written is valid BCD and inside its field's range. Under those conditions the wrap and carry properties describe real calendar behaviour. The stimulus loads only legal dates and times, including February 28/29 in leap and common years and the 99 rollover. It writes out-of-field bits only in the masking checks, and there it uses in-range BCD digits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELD   = 7;
  localparam int ADDR_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int IDX_SEC  = 0;
  localparam int IDX_HR   = 2;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YR   = 6;

  // storage width, wrap (minimum) value, upper limit and carry source per field
  localparam int          FW   [NFIELD] = '{7, 7, 6, 3, 6, 5, 8};
  localparam logic [7:0]  FMIN [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [7:0]  FLIM [NFIELD] = '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
  localparam int          FSRC [NFIELD] = '{-1, 0, 1, 2, 2, 4, 5};

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four: low two bits of the units digit equal twice the tens parity
  function automatic logic bcd_leap(input logic [7:0] y);
    return y[1:0] == {y[4], 1'b0};
  endfunction
endpackage

// File: rtl/cal_month_days.sv
module cal_month_days (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_day
);
  always_comb begin
    unique case (month)
      8'h02:                      last_day = cal_pkg::bcd_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter int         W    = 8,
  parameter logic [7:0] MINV = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] lim,
  output logic [7:0] val,
  output logic       carry
);
  localparam logic [7:0] MASK = 8'((9'd1 << W) - 9'd1);

  logic [W-1:0] q;
  logic [7:0]   nxt;
  logic         at_lim;

  assign val    = 8'(q);
  assign at_lim = val >= lim;
  assign nxt    = at_lim ? MINV : cal_pkg::bcd_next(val);
  assign carry  = inc & ~ld & at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= MINV[W-1:0];
    else if (ld)  q <= ld_val[W-1:0];
    else if (inc) q <= nxt[W-1:0];
  end

  // R9/R10: a load lands, masked to the field width, whatever the tick does
  p_field_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> val == ($past(ld_val) & MASK));

  // R2: an advance at the limit returns the field to its minimum
  p_field_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && at_lim) |=> val == MINV);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        stop_req,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [55:0] cal_bytes,
  output logic        subsec_clr
);
  import cal_pkg::*;

  logic [7:0] fval  [NFIELD];
  logic [7:0] flim  [NFIELD];
  logic       finc  [NFIELD];
  logic       fld   [NFIELD];
  logic       fcar  [NFIELD];
  logic [7:0] last_day;
  logic       st_q, ceb_q, cb_q, halt, adv;

  assign halt = st_q | stop_req;
  assign adv  = tick_1hz & ~halt;

  cal_month_days u_mdays (
    .month    (fval[IDX_MON]),
    .year     (fval[IDX_YR]),
    .last_day (last_day)
  );

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
    assign fld[gi]  = wr_en && (wr_addr == ADDR_W'(gi));
    assign flim[gi] = (gi == IDX_DATE) ? last_day : FLIM[gi];
    if (FSRC[gi] < 0) begin : g_head
      assign finc[gi] = adv;
    end else begin : g_chain
      assign finc[gi] = fcar[FSRC[gi]];
    end
    cal_bcd_field #(.W(FW[gi]), .MINV(FMIN[gi])) u_fld (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (finc[gi]),
      .ld     (fld[gi]),
      .ld_val (wr_data),
      .lim    (flim[gi]),
      .val    (fval[gi]),
      .carry  (fcar[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= 1'b0;
      ceb_q      <= 1'b0;
      cb_q       <= 1'b0;
      subsec_clr <= 1'b0;
    end else begin
      subsec_clr <= fld[IDX_SEC];
      if (fld[IDX_SEC]) st_q <= wr_data[7];
      if (fld[IDX_HR]) begin
        ceb_q <= wr_data[7];
        cb_q  <= wr_data[6];
      end else if (fcar[IDX_YR] && ceb_q) begin
        cb_q  <= ~cb_q;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NFIELD; k++) cal_bytes[8*k +: 8] = fval[k];
    cal_bytes[7]  = st_q;
    cal_bytes[22] = cb_q;
    cal_bytes[23] = ceb_q;
  end

  // R3: while halted and not written, seconds stay put
  p_stop_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !fld[IDX_SEC]) |=> $stable(fval[IDX_SEC]));

  // R8: year rollover with enable set flips the century bit
  p_century_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fcar[IDX_YR] && ceb_q && !fld[IDX_HR]) |=> cb_q != $past(cb_q));

  // R8: with the enable clear and no write, the century bit holds
  p_century_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb_q && !fld[IDX_HR]) |=> $stable(cb_q));

  // R11: prescaler clear follows a seconds write by one cycle
  p_subsec_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    subsec_clr |-> $past(wr_en && wr_addr == 3'd0));

  // R4: day of week never reads zero
  p_dow_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fval[3] != 8'h00);
endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        stop_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [55:0] cal_bytes;
  logic        subsec_clr;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcd_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .stop_req(stop_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_bytes(cal_bytes), .subsec_clr(subsec_clr)
  );

  // {start bytes 6..0, expected bytes 6..0 after one tick}
  localparam int NV = 18;
  localparam logic [111:0] VEC [NV] = '{
    {56'h24_03_15_02_10_20_00, 56'h24_03_15_02_10_20_01},  // R2 plain
    {56'h24_03_15_02_10_20_09, 56'h24_03_15_02_10_20_10},  // R2 digit carry
    {56'h24_03_15_02_10_20_59, 56'h24_03_15_02_10_21_00},  // R2 minute
    {56'h24_03_15_02_10_59_59, 56'h24_03_15_02_11_00_00},  // R2 hour
    {56'h24_03_15_02_19_59_59, 56'h24_03_15_02_20_00_00},  // R2 hour digit
    {56'h24_03_15_07_23_59_59, 56'h24_03_16_01_00_00_00},  // R4 dow wrap
    {56'h24_04_30_03_23_59_59, 56'h24_05_01_04_00_00_00},  // R5 30-day
    {56'h24_03_31_03_23_59_59, 56'h24_04_01_04_00_00_00},  // R5 31-day
    {56'h24_09_30_03_23_59_59, 56'h24_10_01_04_00_00_00},  // R5 september
    {56'h24_11_30_03_23_59_59, 56'h24_12_01_04_00_00_00},  // R5 november
    {56'h24_02_28_03_23_59_59, 56'h24_02_29_04_00_00_00},  // R6 leap 24
    {56'h24_02_29_03_23_59_59, 56'h24_03_01_04_00_00_00},  // R6 leap end
    {56'h23_02_28_03_23_59_59, 56'h23_03_01_04_00_00_00},  // R5 common feb
    {56'h12_02_28_03_23_59_59, 56'h12_02_29_04_00_00_00},  // R6 leap 12
    {56'h10_02_28_03_23_59_59, 56'h10_03_01_04_00_00_00},  // R6 common 10
    {56'h00_02_28_03_23_59_59, 56'h00_02_29_04_00_00_00},  // R6 leap 00
    {56'h24_12_31_06_23_59_59, 56'h25_01_01_07_00_00_00},  // R7 new year
    {56'h99_12_31_05_23_59_59, 56'h00_01_01_06_00_00_00}   // R7 year wrap
  };

  task automatic chk(input string tag, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic tk_wr(input logic [2:0] a, input logic [7:0] d);
    tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0;
  endtask

  task automatic load_all(input logic [55:0] b);
    for (int k = 0; k < 7; k++) wr(3'(k), b[8*k +: 8]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [55:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset bytes", cal_bytes, 56'h00_01_01_01_00_00_00);
    chk("R1 reset subsec_clr", 56'(subsec_clr), 56'h0);

    // R2 R4 R5 R6 R7 table
    for (int v = 0; v < NV; v++) begin
      load_all(VEC[v][111:56]);
      tk();
      chk($sformatf("R2/R4/R5/R6/R7 vector %0d", v), cal_bytes, VEC[v][55:0]);
    end

    // R3 stop bit
    load_all(56'h24_03_15_02_10_20_B0);
    tk(); tk(); tk();
    chk("R3 stop bit freezes", cal_bytes, 56'h24_03_15_02_10_20_B0);
    wr(3'd0, 8'h30);
    stop_req = 1'b1;
    tk(); tk();
    chk("R3 stop_req freezes", cal_bytes, 56'h24_03_15_02_10_20_30);
    stop_req = 1'b0;
    tk();
    chk("R3 resume", cal_bytes, 56'h24_03_15_02_10_20_31);

    // R8 century
    load_all(56'h99_12_31_05_A3_59_59);
    tk();
    chk("R8 century flips", cal_bytes, 56'h00_01_01_06_C0_00_00);
    load_all(56'h99_12_31_05_63_59_59);
    tk();
    chk("R8 century holds", cal_bytes, 56'h00_01_01_06_40_00_00);

    // R9 field masking and ignored address
    load_all(56'h24_03_15_02_10_20_00);
    wr(3'd1, 8'h85); chk("R9 minute mask", 56'(cal_bytes[15:8]), 56'h05);
    wr(3'd3, 8'hFB); chk("R9 day mask", 56'(cal_bytes[31:24]), 56'h03);
    wr(3'd4, 8'hD2); chk("R9 date mask", 56'(cal_bytes[39:32]), 56'h12);
    wr(3'd5, 8'hE9); chk("R9 month mask", 56'(cal_bytes[47:40]), 56'h09);
    snap = cal_bytes;
    wr(3'd7, 8'h55);
    chk("R9 address 7 ignored", cal_bytes, snap);

    // R10 write beats tick
    load_all(56'h24_03_15_02_10_10_59);
    tk_wr(3'd0, 8'h20);
    chk("R10 seconds write wins", cal_bytes, 56'h24_03_15_02_10_10_20);
    load_all(56'h24_03_15_02_10_59_59);
    tk_wr(3'd1, 8'h40);
    chk("R10 minute write wins", cal_bytes, 56'h24_03_15_02_10_40_00);

    // R11 prescaler clear pulse
    wr(3'd0, 8'h11);
    chk("R11 pulse after seconds write", 56'(subsec_clr), 56'h1);
    @(negedge clk);
    chk("R11 pulse one cycle", 56'(subsec_clr), 56'h0);
    wr(3'd1, 8'h22);
    chk("R11 no pulse for minutes", 56'(subsec_clr), 56'h0);

    summary();
    $finish;
  end
endmodule